// File: doc/BRIEF.md
# Auto-Increment Packet Data Port

This block lets a host reach bytes inside fixed-size packet pages through two register slots: a 16-bit pointer and a four-byte data window. The pointer carries a byte offset within a page in its low bits. Two control bits in its top byte choose the page and the addressing mode. Bit 15 selects the page: when it is set, the page is the one at the head of the receive queue, and when it is clear, the page is the one held in the packet-number register. Both page numbers come in as inputs. Queue management and page allocation are handled elsewhere. Bit 14 selects the mode. When it is set, every byte access through the window advances the pointer. When it is clear, the low two bits of the window address are added to the offset.

The host issues 1-, 2- or 4-byte accesses at a 4-bit register address. The block splits each access into byte steps, one per clock, starting at the lowest address. Each step goes either to a pointer byte or, through a single-port byte memory interface, to the page storage. Read bytes are gathered into the matching lanes of the host read word. A one-cycle completion pulse marks the end of the access.

Top module: `pdp_data_port`

## Requirements
- R1: After reset the pointer is 0x0000, `host_busy`, `host_done` and `mem_en` are low, and reading the pointer returns zero.
- R2: Address 6 reads and writes pointer bits 7:0, and address 7 reads and writes bits 15:8. A read of address 7 returns bits 15:8 AND 0xF7, so pointer bit 11 always reads as 0.
- R3: A window access addresses page `rx_head_page` when pointer bit 15 is 1, and page `tx_page` when it is 0.
- R4: When pointer bit 14 is 1, a window access uses offset = pointer bits OFS_W-1:0. Afterwards those bits advance by one modulo 2^OFS_W, and pointer bits 15:OFS_W stay unchanged.
- R5: When pointer bit 14 is 0, a window access at address A uses offset = (pointer bits OFS_W-1:0 + (A AND 3)) modulo 2^OFS_W, and the pointer does not change.
- R6: Addresses 8 to 11 are the data window. A write step drives `mem_en` and `mem_we` with the write byte on `mem_wdata`. A read step drives `mem_en` with `mem_we` low. Reads and writes obey R3 to R5 in the same way.
- R7: An access of `host_size` 0, 1 or 2 covers 1, 2 or 4 bytes. Byte k uses address (`host_addr` + k) mod 16 and write lane k (bits 8k+7:8k), one byte per clock with k ascending. A pointer byte written in an earlier step takes effect for the later steps.
- R8: Read byte k is placed in `host_rdata` lane k, where a window byte is taken from `mem_rdata` one cycle after its `mem_en` step. Lanes beyond the access size read 0. `host_done` pulses for one cycle when the access is complete.
- R9: Addresses 0 to 5 and 12 to 15 read 0. A write to them changes no state and causes no memory access.
- R10: `host_busy` rises the cycle after a request is accepted and falls in the `host_done` cycle. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, accepted when not busy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address of the first byte |
| host_size | input | 2 | 0 = byte, 1 = two bytes, 2 or 3 = four bytes |
| host_wdata | input | 8*HOST_BYTES | Write data, byte k in lane k |
| host_rdata | output | 8*HOST_BYTES | Read data, valid while host_done is high |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| rx_head_page | input | PAGE_W | Page at the head of the receive queue |
| tx_page | input | PAGE_W | Page in the packet-number register |
| mem_en | output | 1 | Page memory byte access strobe |
| mem_we | output | 1 | Page memory write enable |
| mem_page | output | PAGE_W | Page number of the access |
| mem_offset | output | OFS_W | Byte offset within the page |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid one cycle after mem_en |

## Verification
The bench builds the block with PAGE_W=2, OFS_W=11 and HOST_BYTES=4, which gives four pages of 2048 bytes. These defaults let the bench reach the offset wrap at 2047 in both pointer modes. They also allow four-byte accesses that write both pointer bytes and then use the new pointer in the same access. Accesses that wrap from address 15 back to 0 are reachable too. The bench also covers page switches in both directions and a request that arrives while the block is busy.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
   localparam int PTR_W       = 16;
   localparam int SRC_BIT     = 15;
   localparam int INC_BIT     = 14;
   localparam logic [7:0] HI_READ_MASK = 8'hF7;
   localparam logic [3:0] ADR_PTR_LO   = 4'd6;
   localparam logic [3:0] ADR_PTR_HI   = 4'd7;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_PLO  = 2'd1,
      ACC_PHI  = 2'd2,
      ACC_WIN  = 2'd3
   } acc_e;

   function automatic acc_e decode_addr(input logic [3:0] a);
      if (a == ADR_PTR_LO)      return ACC_PLO;
      else if (a == ADR_PTR_HI) return ACC_PHI;
      else if (a[3:2] == 2'b10) return ACC_WIN;
      else                      return ACC_NONE;
   endfunction
endpackage

// File: rtl/pdp_seq.sv
module pdp_seq
   import pdp_pkg::*;
#(
   parameter int HOST_BYTES = 4,
   localparam int DW     = 8 * HOST_BYTES,
   localparam int LANE_W = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1,
   localparam int CNT_W  = LANE_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [3:0]        host_addr,
   input  logic [1:0]        host_size,
   input  logic [DW-1:0]     host_wdata,
   input  logic              fin,
   output logic              accept,
   output logic              busy,
   output logic              issue,
   output logic              last,
   output acc_e              kind,
   output logic [3:0]        cur_addr,
   output logic [LANE_W-1:0] cur_lane,
   output logic              we_o,
   output logic [7:0]        wbyte
);
   logic              busy_q, we_q;
   logic [3:0]        base_q;
   logic [CNT_W-1:0]  cnt_q, nb_q, nb_req;
   logic [DW-1:0]     wdata_q;
   logic [7:0]        wlanes [HOST_BYTES];

   always_comb begin
      unique case (host_size)
         2'd0:    nb_req = CNT_W'(1);
         2'd1:    nb_req = (HOST_BYTES >= 2) ? CNT_W'(2) : CNT_W'(HOST_BYTES);
         default: nb_req = CNT_W'(HOST_BYTES);
      endcase
   end

   assign accept = host_req && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         we_q    <= 1'b0;
         base_q  <= '0;
         cnt_q   <= '0;
         nb_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         we_q    <= host_we;
         base_q  <= host_addr;
         cnt_q   <= '0;
         nb_q    <= nb_req;
         wdata_q <= host_wdata;
      end else begin
         if (issue) cnt_q <= cnt_q + CNT_W'(1);
         if (fin)   busy_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < HOST_BYTES; g++) begin : g_wlane
      assign wlanes[g] = wdata_q[8*g +: 8];
   end

   assign busy     = busy_q;
   assign issue    = busy_q && (cnt_q < nb_q);
   assign last     = issue && (cnt_q == nb_q - CNT_W'(1));
   assign cur_addr = base_q + 4'(cnt_q);
   assign cur_lane = cnt_q[LANE_W-1:0];
   assign kind     = decode_addr(cur_addr);
   assign we_o     = we_q;
   assign wbyte    = wlanes[cur_lane];

   if (!(HOST_BYTES == 1 || HOST_BYTES == 2 || HOST_BYTES == 4)) begin : g_chk_bytes
      $error("pdp_seq: HOST_BYTES must be 1, 2 or 4");
   end

   // R7: one byte step per clock while stepping
   a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !accept) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R10: a running access keeps its request until it finishes
   a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> (busy_q && $stable(base_q) && $stable(we_q)));
endmodule

// File: rtl/pdp_ptr.sv
module pdp_ptr
   import pdp_pkg::*;
#(
   parameter int OFS_W = 11
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wbyte,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   logic [PTR_W-1:0] ptr_q;
   logic [OFS_W-1:0] ofs_next;

   assign ofs_next = ptr_q[OFS_W-1:0] + OFS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         if (wr_lo) ptr_q[7:0]  <= wbyte;
         if (wr_hi) ptr_q[15:8] <= wbyte;
         if (step && ptr_q[INC_BIT]) ptr_q[OFS_W-1:0] <= ofs_next;
      end
   end

   assign ptr = ptr_q;

   if (OFS_W < 4 || OFS_W > 11) begin : g_chk_ofs
      $error("pdp_ptr: OFS_W must lie in 4..11");
   end

   // R4: the offset field advances and the upper bits are kept
   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ptr_q[INC_BIT]) |=>
         ((ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + OFS_W'(1)) &&
          (ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W]))));

   // R5: without increment mode a window access leaves the pointer alone
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ptr_q[INC_BIT]) |=> $stable(ptr_q));
endmodule

// File: rtl/pdp_addr.sv
module pdp_addr #(
   parameter int PAGE_W = 2,
   parameter int OFS_W  = 11
)(
   input  logic              use_rx,
   input  logic              auto_inc,
   input  logic [OFS_W-1:0]  ofs_base,
   input  logic [1:0]        lane_sel,
   input  logic [PAGE_W-1:0] rx_head_page,
   input  logic [PAGE_W-1:0] tx_page,
   output logic [PAGE_W-1:0] page,
   output logic [OFS_W-1:0]  ofs
);
   assign page = use_rx ? rx_head_page : tx_page;
   assign ofs  = auto_inc ? ofs_base : ofs_base + OFS_W'(lane_sel);

   if (PAGE_W < 1 || PAGE_W > 8) begin : g_chk_page
      $error("pdp_addr: PAGE_W must lie in 1..8");
   end
endmodule

// File: rtl/pdp_rdcap.sv
module pdp_rdcap #(
   parameter int HOST_BYTES = 4,
   localparam int DW     = 8 * HOST_BYTES,
   localparam int LANE_W = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              issue,
   input  logic              is_read,
   input  logic              from_mem,
   input  logic              last,
   input  logic [LANE_W-1:0] lane,
   input  logic [7:0]        regbyte,
   input  logic [7:0]        mem_rdata,
   output logic              ending,
   output logic              done,
   output logic [DW-1:0]     rdata
);
   logic              pend_q, mem_q, last_q, done_q;
   logic [LANE_W-1:0] lane_q;
   logic [7:0]        reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mem_q  <= 1'b0;
         last_q <= 1'b0;
         done_q <= 1'b0;
         lane_q <= '0;
         reg_q  <= '0;
      end else begin
         pend_q <= issue && is_read;
         mem_q  <= from_mem;
         last_q <= last;
         done_q <= last_q;
         lane_q <= lane;
         reg_q  <= regbyte;
      end
   end

   for (genvar g = 0; g < HOST_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata[8*g +: 8] <= '0;
         else if (accept)
            rdata[8*g +: 8] <= '0;
         else if (pend_q && lane_q == LANE_W'(g))
            rdata[8*g +: 8] <= mem_q ? mem_rdata : reg_q;
      end
   end

   assign ending = last_q;
   assign done   = done_q;

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/pdp_data_port.sv
module pdp_data_port
   import pdp_pkg::*;
#(
   parameter int PAGE_W     = 2,
   parameter int OFS_W      = 11,
   parameter int HOST_BYTES = 4,
   localparam int DW     = 8 * HOST_BYTES,
   localparam int LANE_W = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [3:0]        host_addr,
   input  logic [1:0]        host_size,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   output logic              host_busy,
   output logic              host_done,
   input  logic [PAGE_W-1:0] rx_head_page,
   input  logic [PAGE_W-1:0] tx_page,
   output logic              mem_en,
   output logic              mem_we,
   output logic [PAGE_W-1:0] mem_page,
   output logic [OFS_W-1:0]  mem_offset,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   logic              accept, busy, issue, last, we, ending;
   acc_e              kind;
   logic [3:0]        cur_addr;
   logic [LANE_W-1:0] cur_lane;
   logic [7:0]        wbyte, regbyte;
   logic [PTR_W-1:0]  ptr;
   logic              win_step;

   pdp_seq #(.HOST_BYTES(HOST_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata), .fin(ending),
      .accept(accept), .busy(busy), .issue(issue), .last(last),
      .kind(kind), .cur_addr(cur_addr), .cur_lane(cur_lane),
      .we_o(we), .wbyte(wbyte)
   );

   assign win_step = issue && (kind == ACC_WIN);

   pdp_ptr #(.OFS_W(OFS_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(issue && we && kind == ACC_PLO),
      .wr_hi(issue && we && kind == ACC_PHI),
      .wbyte(wbyte), .step(win_step), .ptr(ptr)
   );

   pdp_addr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_addr (
      .use_rx(ptr[SRC_BIT]), .auto_inc(ptr[INC_BIT]),
      .ofs_base(ptr[OFS_W-1:0]), .lane_sel(cur_addr[1:0]),
      .rx_head_page(rx_head_page), .tx_page(tx_page),
      .page(mem_page), .ofs(mem_offset)
   );

   always_comb begin
      unique case (kind)
         ACC_PLO: regbyte = ptr[7:0];
         ACC_PHI: regbyte = ptr[15:8] & HI_READ_MASK;
         default: regbyte = 8'h00;
      endcase
   end

   pdp_rdcap #(.HOST_BYTES(HOST_BYTES)) u_rdcap (
      .clk(clk), .rst_n(rst_n), .accept(accept), .issue(issue),
      .is_read(!we), .from_mem(kind == ACC_WIN), .last(last),
      .lane(cur_lane), .regbyte(regbyte), .mem_rdata(mem_rdata),
      .ending(ending), .done(host_done), .rdata(host_rdata)
   );

   assign mem_en    = win_step;
   assign mem_we    = win_step && we;
   assign mem_wdata = wbyte;
   assign host_busy = busy;

   // R10: the memory port stays quiet while no access runs
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !host_busy |-> !mem_en);

   // R1: the first cycle after reset shows an idle port
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!host_busy && !host_done));
endmodule

// File: tb/tb_pdp_data_port.sv
module tb_pdp_data_port;
   localparam int CLK_PERIOD = 10;
   localparam int PAGE_W = 2;
   localparam int OFS_W  = 11;
   localparam int HB     = 4;
   localparam int OMASK  = (1 << OFS_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_req = 1'b0, host_we = 1'b0;
   logic [3:0] host_addr = '0;
   logic [1:0] host_size = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic host_busy, host_done;
   logic [PAGE_W-1:0] rx_head_page = '0, tx_page = '0, mem_page;
   logic mem_en, mem_we;
   logic [OFS_W-1:0] mem_offset;
   logic [7:0] mem_wdata, mem_rdata = '0;

   int total = 0, bad = 0;
   string cur_tag = "R1";
   int mptr = 0;
   logic [7:0] ram [int];
   logic [7:0] shadow [int];
   int q_page[$], q_ofs[$], q_we[$], q_wd[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pdp_data_port #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .HOST_BYTES(HB)) dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_busy(host_busy), .host_done(host_done),
      .rx_head_page(rx_head_page), .tx_page(tx_page),
      .mem_en(mem_en), .mem_we(mem_we), .mem_page(mem_page),
      .mem_offset(mem_offset), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // page storage
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[{mem_page, mem_offset}] = mem_wdata;
         else mem_rdata <= ram.exists({mem_page, mem_offset}) ? ram[{mem_page, mem_offset}] : 8'h00;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison of the memory port against the model's queue
   always @(negedge clk) begin
      if (rst_n && mem_en) begin
         if (q_page.size() == 0) begin
            check(1'b0, cur_tag, "unexpected mem_en", 1, 0);
         end else begin
            int ep, eo, ew, ed;
            ep = q_page.pop_front(); eo = q_ofs.pop_front();
            ew = q_we.pop_front();   ed = q_wd.pop_front();
            check(mem_page == PAGE_W'(ep), cur_tag, "mem_page (R3)", mem_page, ep);
            check(mem_offset == OFS_W'(eo), cur_tag, "mem_offset (R4/R5)", mem_offset, eo);
            check(mem_we == ew[0], cur_tag, "mem_we (R6)", mem_we, ew);
            if (ew != 0) check(mem_wdata == 8'(ed), cur_tag, "mem_wdata (R6)", mem_wdata, ed);
         end
      end
   end

   // behavioural reference of one host access
   task automatic model_op(input logic [3:0] a0, input logic [1:0] sz, input bit w,
                           input logic [31:0] wd, output logic [31:0] exp);
      int n;
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      exp = '0;
      for (int k = 0; k < n; k++) begin
         int a, b;
         a = (a0 + k) & 15;
         b = (wd >> (8 * k)) & 8'hFF;
         if (a == 6) begin
            if (w) mptr = (mptr & 16'hFF00) | b;
            else exp |= 32'(mptr & 8'hFF) << (8 * k);
         end else if (a == 7) begin
            if (w) mptr = (mptr & 16'h00FF) | (b << 8);
            else exp |= 32'((mptr >> 8) & 8'hF7) << (8 * k);
         end else if (a >= 8 && a <= 11) begin
            int pg, of, key;
            pg = mptr[15] ? int'(rx_head_page) : int'(tx_page);
            of = mptr[14] ? (mptr & OMASK) : (((mptr & OMASK) + (a & 3)) & OMASK);
            key = (pg << OFS_W) | of;
            q_page.push_back(pg); q_ofs.push_back(of);
            q_we.push_back(w ? 1 : 0); q_wd.push_back(b);
            if (w) shadow[key] = 8'(b);
            else exp |= 32'(shadow.exists(key) ? shadow[key] : 8'h00) << (8 * k);
            if (mptr[14]) mptr = (mptr & ~OMASK) | ((mptr + 1) & OMASK);
         end
      end
   endtask

   task automatic do_op(input logic [3:0] a, input logic [1:0] sz, input bit w,
                        input logic [31:0] wd, input string tag, input bit intrude);
      logic [31:0] exp;
      int waited;
      model_op(a, sz, w, wd, exp);
      cur_tag = tag;
      host_addr = a; host_size = sz; host_we = w; host_wdata = wd; host_req = 1'b1;
      @(negedge clk);
      check(host_busy == 1'b1, "R10", "busy after accept", host_busy, 1);
      if (intrude) begin
         host_addr = 4'd6; host_size = 2'd0; host_we = 1'b1; host_wdata = 32'h55;
         @(negedge clk);
      end
      host_req = 1'b0;
      waited = 0;
      while (!host_done && waited < 30) begin
         @(negedge clk);
         waited++;
      end
      check(host_done == 1'b1, tag, "host_done seen (R8)", host_done, 1);
      check(host_busy == 1'b0, "R10", "busy low in done cycle", host_busy, 0);
      if (!w) check(host_rdata == exp, tag, "host_rdata", host_rdata, exp);
      check(q_page.size() == 0, tag, "pending memory steps", q_page.size(), 0);
      @(negedge clk);
      check(host_done == 1'b0, "R8", "done is one pulse", host_done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R10", "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(host_busy == 1'b0, "R1", "busy after reset", host_busy, 0);
      check(host_done == 1'b0, "R1", "done after reset", host_done, 0);
      check(mem_en == 1'b0, "R1", "mem_en after reset", mem_en, 0);
      do_op(4'd6, 2'd1, 1'b0, 0, "R1", 1'b0);

      // R2 pointer bytes, bit 11 reads 0
      do_op(4'd6, 2'd1, 1'b1, 32'h4FFE, "R2", 1'b0);
      do_op(4'd6, 2'd1, 1'b0, 0, "R2", 1'b0);
      do_op(4'd7, 2'd0, 1'b0, 0, "R2", 1'b0);

      // R4 auto increment across the offset wrap, R7 four-byte split
      tx_page = 2'd1; rx_head_page = 2'd2;
      do_op(4'd8, 2'd2, 1'b1, 32'hA1B2C3D4, "R4", 1'b0);
      do_op(4'd6, 2'd1, 1'b0, 0, "R4", 1'b0);
      do_op(4'd6, 2'd1, 1'b1, 32'h4FFE, "R6", 1'b0);
      do_op(4'd10, 2'd2, 1'b0, 0, "R6", 1'b0);

      // R5 fixed pointer, window address adds to the offset with wrap
      do_op(4'd6, 2'd1, 1'b1, 32'h07FE, "R5", 1'b0);
      do_op(4'd9, 2'd0, 1'b1, 32'h11, "R5", 1'b0);
      do_op(4'd11, 2'd0, 1'b1, 32'h22, "R5", 1'b0);
      do_op(4'd8, 2'd2, 1'b0, 0, "R5", 1'b0);
      do_op(4'd6, 2'd1, 1'b0, 0, "R5", 1'b0);

      // R3 page source
      do_op(4'd6, 2'd1, 1'b1, 32'hC010, "R3", 1'b0);
      do_op(4'd8, 2'd2, 1'b1, 32'h99887766, "R3", 1'b0);
      do_op(4'd6, 2'd1, 1'b1, 32'h4010, "R3", 1'b0);
      do_op(4'd8, 2'd2, 1'b0, 0, "R3", 1'b0);
      rx_head_page = 2'd3;
      do_op(4'd6, 2'd1, 1'b1, 32'hC010, "R3", 1'b0);
      do_op(4'd8, 2'd2, 1'b0, 0, "R3", 1'b0);

      // R9 unmapped addresses
      do_op(4'd3, 2'd0, 1'b1, 32'hFF, "R9", 1'b0);
      do_op(4'd12, 2'd1, 1'b1, 32'hFFFF, "R9", 1'b0);
      do_op(4'd0, 2'd2, 1'b0, 0, "R9", 1'b0);
      do_op(4'd14, 2'd2, 1'b0, 0, "R9", 1'b0);
      do_op(4'd6, 2'd1, 1'b0, 0, "R9", 1'b0);

      // R7 pointer written then used inside one access
      do_op(4'd6, 2'd2, 1'b1, 32'h5A3C4005, "R7", 1'b0);
      do_op(4'd6, 2'd2, 1'b0, 0, "R7", 1'b0);

      // R10 request while busy is ignored
      do_op(4'd8, 2'd2, 1'b0, 0, "R10", 1'b1);
      do_op(4'd6, 2'd1, 1'b0, 0, "R10", 1'b0);

      // R8 mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [3:0] a;
         a = (i % 5 == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(6, 11));
         if (i % 17 == 0) begin
            rx_head_page = PAGE_W'($urandom);
            tx_page = PAGE_W'($urandom);
         end
         do_op(a, 2'($urandom_range(0, 3)), 1'($urandom), $urandom, "R8", 1'b0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule